// File: doc/BRIEF.md
# Packed Vector Lane Unpacker

This block turns packed source vectors into a sequence of 32-bit lane writes, one lane per clock, for a downstream masked-write stage. Each source beat carries the elements of one vector. The unpacker walks a 2-bit lane pointer through X, Y, Z and W (indices 0 to 3). For each lane it picks an element, or a field of the colour word. It then sign- or zero-extends that value and offers it on a valid/ready lane port.

A separate remaining-element count limits how many counted lanes may be produced. Some lanes of the 2- and 3-component formats are padding lanes. A padding lane is produced without spending the count. The lane pointer keeps its position across count reloads, so a vector interrupted by an empty count resumes at the lane where it stopped.

The format is selected by a vector-shape code and an element-kind code. A signed flag chooses between sign and zero extension. A shape/kind pair that has no meaning raises an error flag and produces no lanes.

Top module: `vec_unpacker`

## Requirements
- R1: After reset the lane index is 0, the remaining count is 0, and with no source beat present `laneValid`, `srcReady` and `fmtErr` are all 0.
- R2: Each accepted lane (`laneValid` and `laneReady` both 1) advances `laneIdx` by one, wrapping from 3 to 0. `srcReady` is 1 only in the cycle that the W lane (index 3) is accepted, and that is when the beat is consumed.
- R3: Shape code 0 (scalar) sends element 0 of the beat to all four lanes, and every lane is counted.
- R4: Shape code 1 (2-component) gives X = element 0, Y = element 1 and Z = element 0. W is 0 for 32-bit elements and element 1 for 16- and 8-bit elements. X and Y are counted; Z and W are not.
- R5: Shape code 2 (3-component) gives X, Y, Z, W = elements 0, 1, 2, 3. X, Y and Z are counted; W is not.
- R6: Shape code 3 (4-component) gives lane i = element i, and all four lanes are counted.
- R7: Element-kind code 3 with shape code 3 is the colour format, read from beat bits [15:0]. X = bits[4:0]<<3, Y = bits[9:5]<<3, Z = bits[14:10]<<3, W = bit 15 placed at bit 7. All other bits are 0, and all four lanes are counted.
- R8: Element-kind codes 0, 1 and 2 mean 32-, 16- and 8-bit elements. Element i sits at beat bits [i*w +: w]. With `signedEn` = 1, 16- and 8-bit elements are sign-extended to 32 bits; otherwise they are zero-extended.
- R9: A counted lane is offered only while the remaining count is nonzero, and each accepted counted lane lowers the count by one. A `loadCount` pulse sets the count to `countIn` and takes priority over the decrement. While the count is 0, a counted lane waits without moving `laneIdx`.
- R10: Padding (uncounted) lanes are offered whenever a beat is present, even with a count of 0, and they leave the count unchanged.
- R11: Element-kind code 3 with any shape code other than 3 sets `fmtErr` and holds `laneValid` and `srcReady` at 0.
- R12: While `laneValid` is 1 and `laneReady` is 0, `laneIdx`, `laneData` and the count hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vecSel | input | 2 | Vector shape: 0 scalar, 1 two, 2 three, 3 four components |
| elemSel | input | 2 | Element kind: 0 32-bit, 1 16-bit, 2 8-bit, 3 colour 5:5:5:1 |
| signedEn | input | 1 | Sign-extend 16- and 8-bit elements when 1 |
| srcValid | input | 1 | A source beat is present |
| srcData | input | 128 | Source beat holding the elements of one vector |
| srcReady | output | 1 | Beat consumed this cycle |
| loadCount | input | 1 | Load the remaining count from countIn |
| countIn | input | 16 | Remaining count value to load |
| laneValid | output | 1 | A lane value is offered |
| laneReady | input | 1 | Downstream accepts the lane |
| laneIdx | output | 2 | Lane index, X=0 to W=3 |
| laneData | output | 32 | Lane value |
| fmtErr | output | 1 | Unsupported shape/kind combination |

## Verification
On every cycle the assertions check the following: the lane pointer steps by one on each accepted lane, beats are consumed only on the W lane, padding lanes are never blocked by the count, a bad format stays silent, an accepted counted lane lowers the count, and a stalled lane holds still. A scalar beat is also checked to keep its value from lane to lane. The lane values themselves can only be shown by the bench scenarios. These cover the element and field mapping of each format, sign and zero extension, the W padding rules, and a vector that stops part-way when the count runs out and resumes after a reload. The bench compares each of them against its reference model.

// File: rtl/vec_unpack_pkg.sv
package vec_unpack_pkg;

  localparam int LANES = 4;
  localparam int LANE_IDX_W = $clog2(LANES);

  typedef enum logic [1:0] {
    VK_SCALAR = 2'd0,
    VK_PAIR   = 2'd1,
    VK_TRIPLE = 2'd2,
    VK_QUAD   = 2'd3
  } vecKind_e;

  typedef enum logic [1:0] {
    EK_W32   = 2'd0,
    EK_W16   = 2'd1,
    EK_W8    = 2'd2,
    EK_C5551 = 2'd3
  } elemKind_e;

  // Strobes from the lane controller to the datapath.
  typedef struct packed {
    logic [LANE_IDX_W-1:0] lane;
    logic                  fire;
  } laneStrobe_t;

  // A lane spends the remaining count unless it is a padding lane.
  function automatic logic laneCounted(vecKind_e vk, logic [LANE_IDX_W-1:0] lane);
    case (vk)
      VK_PAIR:   return lane < 2;
      VK_TRIPLE: return lane < 3;
      default:   return 1'b1;
    endcase
  endfunction

  function automatic logic fmtIllegal(vecKind_e vk, elemKind_e ek);
    return (ek == EK_C5551) && (vk != VK_QUAD);
  endfunction

endpackage

// File: rtl/vec_unpack_ctrl.sv
module vec_unpack_ctrl
  import vec_unpack_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  vecKind_e         vecKind,
  input  elemKind_e        elemKind,
  input  logic             srcValid,
  input  logic             laneReady,
  input  logic             loadCount,
  input  logic [CNT_W-1:0] countIn,
  output logic             srcReady,
  output logic             laneValid,
  output logic             fmtErr,
  output laneStrobe_t      strb
);

  localparam logic [LANE_IDX_W-1:0] LAST_LANE = LANE_IDX_W'(LANES - 1);

  logic [LANE_IDX_W-1:0] laneQ;
  logic [CNT_W-1:0]      cntQ;
  logic                  counted;
  logic                  cntEmpty;
  logic                  fire;

  always_comb begin
    fmtErr    = fmtIllegal(vecKind, elemKind);
    counted   = laneCounted(vecKind, laneQ);
    cntEmpty  = (cntQ == '0);
    laneValid = srcValid && !fmtErr && (!counted || !cntEmpty);
    fire      = laneValid && laneReady;
    srcReady  = fire && (laneQ == LAST_LANE);
    strb.lane = laneQ;
    strb.fire = fire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      laneQ <= '0;
      cntQ  <= '0;
    end else begin
      if (fire) laneQ <= laneQ + 1'b1;
      if (loadCount)             cntQ <= countIn;
      else if (fire && counted)  cntQ <= cntQ - 1'b1;
    end
  end

  AST_LANE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> laneQ == $past(laneQ) + 1'b1);  // R2

  AST_POP_ON_LAST: assert property (@(posedge clk) disable iff (!rstN)
    srcReady |-> (laneQ == LAST_LANE) && laneReady);  // R2

  AST_CNT_SPEND: assert property (@(posedge clk) disable iff (!rstN)
    (fire && counted && !loadCount) |=> cntQ == $past(cntQ) - 1'b1);  // R9

  AST_PAD_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (srcValid && !fmtErr && !counted) |-> laneValid);  // R10

  AST_BAD_FMT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    fmtErr |-> !laneValid && !srcReady);  // R11

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (laneValid && !laneReady && !loadCount) |=> $stable(laneQ) && $stable(cntQ));  // R12

endmodule

// File: rtl/vec_unpack_dp.sv
module vec_unpack_dp
  import vec_unpack_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  vecKind_e                vecKind,
  input  elemKind_e               elemKind,
  input  logic                    signedEn,
  input  logic [LANES*LANE_W-1:0] srcData,
  input  laneStrobe_t             strb,
  output logic [LANE_W-1:0]       laneData
);

  localparam int HALF_W  = LANE_W / 2;
  localparam int QTR_W   = LANE_W / 4;
  localparam int CF_W    = 5;
  localparam int CF_SH   = 3;
  localparam int ALPHA_B = 15;
  localparam int ALPHA_P = 7;

  logic [LANE_W-1:0] el32 [LANES];
  logic [LANE_W-1:0] el16 [LANES];
  logic [LANE_W-1:0] el8  [LANES];
  logic [LANE_W-1:0] colr [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_elem
    logic [HALF_W-1:0] h;
    logic [QTR_W-1:0]  q;
    assign h       = srcData[i*HALF_W +: HALF_W];
    assign q       = srcData[i*QTR_W +: QTR_W];
    assign el32[i] = srcData[i*LANE_W +: LANE_W];
    assign el16[i] = {{(LANE_W-HALF_W){signedEn & h[HALF_W-1]}}, h};
    assign el8[i]  = {{(LANE_W-QTR_W){signedEn & q[QTR_W-1]}}, q};
    if (i < LANES - 1) begin : g_field
      assign colr[i] = {{(LANE_W-CF_W-CF_SH){1'b0}}, srcData[i*CF_W +: CF_W], {CF_SH{1'b0}}};
    end else begin : g_alpha
      assign colr[i] = {{(LANE_W-ALPHA_P-1){1'b0}}, srcData[ALPHA_B], {ALPHA_P{1'b0}}};
    end
  end

  logic [LANE_IDX_W-1:0] pick;
  logic                  padZero;

  // Element index feeding the current lane, by vector shape.
  always_comb begin
    pick    = strb.lane;
    padZero = 1'b0;
    case (vecKind)
      VK_SCALAR: pick = '0;
      VK_PAIR: begin
        pick    = {1'b0, strb.lane[0]};
        padZero = (strb.lane == LANE_IDX_W'(LANES - 1)) && (elemKind == EK_W32);
      end
      default: pick = strb.lane;
    endcase
  end

  always_comb begin
    case (elemKind)
      EK_W32:  laneData = padZero ? '0 : el32[pick];
      EK_W16:  laneData = el16[pick];
      EK_W8:   laneData = el8[pick];
      default: laneData = colr[strb.lane];
    endcase
  end

  AST_SCALAR_BCAST: assert property (@(posedge clk) disable iff (!rstN)
    (vecKind == VK_SCALAR && strb.lane != '0 && $past(strb.fire) && $stable(srcData)
     && $stable(vecKind) && $stable(elemKind) && $stable(signedEn)) |-> $stable(laneData));  // R3

endmodule

// File: rtl/vec_unpacker.sv
module vec_unpacker
  import vec_unpack_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int CNT_W  = 16,
  localparam int BEAT_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        vecSel,
  input  logic [1:0]        elemSel,
  input  logic              signedEn,
  input  logic              srcValid,
  input  logic [BEAT_W-1:0] srcData,
  output logic              srcReady,
  input  logic              loadCount,
  input  logic [CNT_W-1:0]  countIn,
  output logic              laneValid,
  input  logic              laneReady,
  output logic [1:0]        laneIdx,
  output logic [LANE_W-1:0] laneData,
  output logic              fmtErr
);

  vecKind_e    vecKind;
  elemKind_e   elemKind;
  laneStrobe_t strb;

  assign vecKind  = vecKind_e'(vecSel);
  assign elemKind = elemKind_e'(elemSel);
  assign laneIdx  = strb.lane;

  vec_unpack_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .vecKind   (vecKind),
    .elemKind  (elemKind),
    .srcValid  (srcValid),
    .laneReady (laneReady),
    .loadCount (loadCount),
    .countIn   (countIn),
    .srcReady  (srcReady),
    .laneValid (laneValid),
    .fmtErr    (fmtErr),
    .strb      (strb)
  );

  vec_unpack_dp #(.LANE_W(LANE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .vecKind  (vecKind),
    .elemKind (elemKind),
    .signedEn (signedEn),
    .srcData  (srcData),
    .strb     (strb),
    .laneData (laneData)
  );

endmodule

// File: tb/tb_vec_unpacker.sv
module tb_vec_unpacker;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   vecSel = 2'd0, elemSel = 2'd0;
  logic         signedEn = 1'b0;
  logic         srcValid = 1'b0;
  logic [127:0] srcData = '0;
  logic         srcReady;
  logic         loadCount = 1'b0;
  logic [15:0]  countIn = '0;
  logic         laneValid;
  logic         laneReady = 1'b1;
  logic [1:0]   laneIdx;
  logic [31:0]  laneData;
  logic         fmtErr;

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;
  bit bpOn = 0;

  logic [127:0] beats[$];
  int mOff = 0;
  int mCnt = 0;

  always #10 clk = ~clk;  // 50 MHz

  vec_unpacker dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !finished) begin
      errors++; checks++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic ck(input bit ok, input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] elemAt(logic [127:0] b, int ek, bit sg, int i);
    logic [15:0] h; logic [7:0] q;
    if (ek == 0) return b[32*i +: 32];
    if (ek == 1) begin h = b[16*i +: 16]; return (sg && h[15]) ? {16'hFFFF, h} : {16'h0, h}; end
    q = b[8*i +: 8];
    return (sg && q[7]) ? {24'hFFFFFF, q} : {24'h0, q};
  endfunction

  function automatic logic [31:0] expLane(int vk, int ek, bit sg, logic [127:0] b, int ln);
    if (ek == 3) begin
      case (ln)
        0: return {24'h0, b[4:0], 3'b000};
        1: return {24'h0, b[9:5], 3'b000};
        2: return {24'h0, b[14:10], 3'b000};
        default: return b[15] ? 32'h80 : 32'h0;
      endcase
    end
    if (vk == 0) return elemAt(b, ek, sg, 0);
    if (vk == 1) begin
      if (ln < 2) return elemAt(b, ek, sg, ln);
      if (ln == 2) return elemAt(b, ek, sg, 0);
      return (ek == 0) ? 32'h0 : elemAt(b, ek, sg, 1);
    end
    return elemAt(b, ek, sg, ln);
  endfunction

  function automatic bit isCnt(int vk, int ln);
    if (vk == 1) return ln < 2;
    if (vk == 2) return ln < 3;
    return 1;
  endfunction

  task automatic drive();
    srcValid = beats.size() > 0;
    srcData  = (beats.size() > 0) ? beats[0] : '0;
    laneReady = bpOn ? ((cyc % 3) != 1) : 1'b1;
  endtask

  task automatic cycle(input string tag);
    bit bad, cntd, eValid, eFire;
    @(negedge clk);
    bad    = (elemSel == 2'd3) && (vecSel != 2'd3);
    cntd   = isCnt(vecSel, mOff);
    eValid = (beats.size() > 0) && !bad && (!cntd || mCnt != 0);
    eFire  = eValid && laneReady;
    ck(laneValid == eValid, tag, "laneValid", 32'(laneValid), 32'(eValid));
    ck(fmtErr == bad, (bad ? "R11" : tag), "fmtErr", 32'(fmtErr), 32'(bad));
    ck(srcReady == (eFire && mOff == 3), "R2", "srcReady", 32'(srcReady), 32'(eFire && mOff == 3));
    if (eValid) begin
      ck(laneIdx == 2'(mOff), (laneReady ? "R2" : "R12"), "laneIdx", 32'(laneIdx), 32'(mOff));
      ck(laneData == expLane(vecSel, elemSel, signedEn, beats[0], mOff), tag, "laneData",
         laneData, expLane(vecSel, elemSel, signedEn, beats[0], mOff));
    end
    if (loadCount) mCnt = countIn;
    else if (eFire && cntd) mCnt--;
    if (eFire) begin
      if (mOff == 3) void'(beats.pop_front());
      mOff = (mOff + 1) % 4;
    end
    @(posedge clk); #1;
    loadCount = 1'b0;
    drive();
  endtask

  task automatic setup(input int vk, input int ek, input bit sg, input int cnt);
    vecSel = 2'(vk); elemSel = 2'(ek); signedEn = sg;
    loadCount = 1'b1; countIn = 16'(cnt);
    drive();
  endtask

  task automatic drain(input string tag);
    for (int n = 0; n < 80 && beats.size() > 0; n++) cycle(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    ck(laneIdx == 2'd0, "R1", "laneIdx", 32'(laneIdx), 0);
    ck(!laneValid, "R1", "laneValid", 32'(laneValid), 0);
    ck(!srcReady, "R1", "srcReady", 32'(srcReady), 0);
    ck(!fmtErr, "R1", "fmtErr", 32'(fmtErr), 0);
    @(posedge clk); #1;

    // R6: four 32-bit components, two beats
    beats.push_back({32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111});
    beats.push_back({32'hDDDD0004, 32'hCCCC0003, 32'hBBBB0002, 32'hAAAA0001});
    setup(3, 0, 0, 8); drain("R6");

    // R3/R8: scalar, signed 16-bit
    beats.push_back({112'h0, 16'h8001});
    setup(0, 1, 1, 4); drain("R3");
    // R8: scalar, unsigned 8-bit
    beats.push_back({120'h0, 8'hF0});
    setup(0, 2, 0, 4); drain("R8");

    // R4/R10: pair of 32-bit, count spent by X,Y; Z,W still produced
    beats.push_back({64'h0, 32'h0000BEEF, 32'h0000CAFE});
    setup(1, 0, 0, 2); drain("R4");
    ck(mCnt == 0, "R10", "model count", 32'(mCnt), 0);
    // R4: pair of unsigned 8-bit, W repeats element 1
    beats.push_back({112'h0, 8'h9A, 8'h7F});
    setup(1, 2, 0, 2); drain("R4");
    // R4: pair of signed 16-bit
    beats.push_back({96'h0, 16'hFFFE, 16'h0005});
    setup(1, 1, 1, 2); drain("R4");

    // R5: triple signed 16-bit, W uncounted
    beats.push_back({64'h0, 16'h8000, 16'h7FFF, 16'hFF00, 16'h0012});
    setup(2, 1, 1, 3); drain("R5");

    // R7: colour words
    beats.push_back({112'h0, 16'hFFFF});
    beats.push_back({112'h0, 16'h5A35});
    setup(3, 3, 1, 8); drain("R7");

    // R12: backpressure, four signed 8-bit
    bpOn = 1;
    beats.push_back({96'h0, 8'h80, 8'h01, 8'hFF, 8'h7E});
    beats.push_back({96'h0, 8'h12, 8'h34, 8'h56, 8'h78});
    setup(3, 2, 1, 8); drain("R12");
    bpOn = 0;

    // R9: count runs out mid-vector, then reload resumes at Z
    beats.push_back({32'h40, 32'h30, 32'h20, 32'h10});
    setup(3, 0, 0, 2);
    for (int n = 0; n < 6; n++) cycle("R9");
    ck(mOff == 2, "R9", "model lane after stall", 32'(mOff), 2);
    loadCount = 1'b1; countIn = 16'd2;
    drain("R9");

    // R11: illegal colour kind with scalar shape
    beats.push_back({112'h0, 16'h1234});
    setup(0, 3, 0, 4);
    for (int n = 0; n < 4; n++) cycle("R11");
    beats.delete();
    drive();
    cycle("R11");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule